// File: doc/BRIEF.md
# Pointer-Indexed Serial Channel Register File

This block is the register access path of a single serial channel. Software reaches it through two byte-wide ports. The control port is two-phase. While the internal register pointer is zero, a write to the control port loads the pointer. The next control-port access, read or write, goes to the register the pointer names, and the pointer then falls back to zero. Every register access therefore needs a fresh pointer write in front of it. A control-port read made while the pointer is zero returns the status register and leaves the pointer at zero.

The data port bypasses the pointer. A write goes to the transmit data latch and a read comes from the receive data latch. The serial shifter is not part of this block. Two strobes stand in for it. One says the transmit latch has been taken. The other delivers a received byte. These strobes drive the TX-empty and RX-available status flags. Two of the control registers hold the 16-bit baud time constant, and the block drives that value straight out to the baud generator.

Top module: `sccr_regfile`

## Requirements
- R1: A control-port write made while the pointer is zero loads the pointer from the low 4 bits of the written byte, and the upper bits are dropped. Loading 0 leaves the block in the pointer-load phase, so the next control read returns status.
- R2: When the pointer is non-zero, the next control-port access reads or writes the register it names, and the pointer then returns to zero.
- R3: A control-port read made while the pointer is zero returns the status register and leaves the pointer at zero.
- R4: Status byte layout: bit 0 = 1 means a received byte is waiting, bit 2 = 1 means the transmit latch is empty, and every other bit reads 0.
- R5: A data-port write loads the transmit latch, which drives `tx_data`, and clears TX-empty. A `tx_accept` pulse sets TX-empty again. If a data-port write and `tx_accept` arrive in the same cycle, the write wins and TX-empty stays clear.
- R6: An `rx_strobe` pulse captures `rx_byte` and sets RX-available. A data-port read returns the receive latch and clears RX-available. If an `rx_strobe` and a data-port read arrive in the same cycle, the read returns the old byte, the new byte is kept, and RX-available stays set.
- R7: `baud_tc` equals {register 13, register 12} (high byte, low byte). It changes in the cycle after one of those registers is written and holds its value otherwise.
- R8: Read data appears on `rd_data` with `rd_valid` high one cycle after a read access. `rd_valid` is low after a write or an idle cycle.
- R9: A synchronous reset clears the pointer, every control register, `baud_tc` and RX-available, and sets TX-empty.
- R10: Data-port accesses leave the pointer alone. A loaded pointer survives any data-port reads and writes and is used by the next control-port access.
- R11: Reading register n (1 to 15) through the pointer returns the last value written to register n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is made this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_data_port | input | 1 | 1 = data port, 0 = control port |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read result valid (one cycle after the read) |
| rd_data | output | 8 | Read result |
| tx_data | output | 8 | Transmit data latch |
| tx_loaded | output | 1 | Transmit latch holds an unsent byte (inverse of TX-empty) |
| tx_accept | input | 1 | Shifter took the transmit byte |
| rx_strobe | input | 1 | A received byte is presented on rx_byte |
| rx_byte | input | 8 | Received byte |
| baud_tc | output | 16 | Baud time constant |

## Verification
A pointer stuck in the wrong phase shows up on the very next control access. A status read returns a register value, or a register access returns the status byte, one cycle after the read. A pointer that is not cleared after an access shows up at the second of two back-to-back control reads. Wrong flag state shows up in the status byte one cycle after the next status read. The simultaneous strobe-and-access cases are exercised because a wrong priority there only appears as a lost byte or a stale flag.

// File: rtl/sccr_pkg.sv
package sccr_pkg;
  localparam int DATA_W  = 8;
  localparam int PTR_W   = 4;
  localparam int NREG    = 1 << PTR_W;
  localparam int BAUD_LO = 12;
  localparam int BAUD_HI = 13;
  localparam int STAT_RX_BIT = 0;
  localparam int STAT_TX_BIT = 2;

  typedef enum logic {PORT_CTRL = 1'b0, PORT_DATA = 1'b1} port_e;
endpackage

// File: rtl/sccr_ptr.sv
module sccr_ptr #(
  parameter int PTR_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              ctrl_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic              stat_rd
);
  logic [PTR_W-1:0] ptr_q;
  logic             armed;
  logic             load;
  logic             consume;

  assign armed   = (ptr_q != '0);
  assign load    = ctrl_wr && !armed;
  assign consume = (ctrl_wr || ctrl_rd) && armed;

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= '0;
    else if (load)    ptr_q <= wdata[PTR_W-1:0];
    else if (consume) ptr_q <= '0;
  end

  assign ptr     = ptr_q;
  assign reg_wr  = ctrl_wr && armed;
  assign reg_rd  = ctrl_rd && armed;
  assign stat_rd = ctrl_rd && !armed;

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ptr_q == '0) |=> ptr_q == $past(wdata[PTR_W-1:0])); // R1
  AST_PTR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((ctrl_wr || ctrl_rd) && ptr_q != '0) |=> ptr_q == '0); // R2
  AST_STATUS_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd && !ctrl_wr && ptr_q == '0) |=> ptr_q == '0); // R3
  AST_PTR_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_rd && !ctrl_wr) |=> $stable(ptr_q)); // R10
endmodule

// File: rtl/sccr_bank.sv
module sccr_bank #(
  parameter int PTR_W   = 4,
  parameter int DATA_W  = 8,
  parameter int BAUD_LO = 12,
  parameter int BAUD_HI = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [PTR_W-1:0]    idx,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [2*DATA_W-1:0] baud_tc
);
  localparam int NREG = 1 << PTR_W;

  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[idx] <= wdata;
    end
  end

  assign rdata   = regs[idx];
  assign baud_tc = {regs[BAUD_HI], regs[BAUD_LO]};

  AST_BAUD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || (idx != PTR_W'(BAUD_LO) && idx != PTR_W'(BAUD_HI)))
      |=> $stable(baud_tc)); // R7
  AST_BAUD_LO_WR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == PTR_W'(BAUD_LO)) |=> baud_tc[DATA_W-1:0] == $past(wdata)); // R7
endmodule

// File: rtl/sccr_latch.sv
module sccr_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_in,
  input  logic              tx_accept,
  input  logic              rx_rd,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_in,
  output logic [DATA_W-1:0] tx_q,
  output logic              tx_empty,
  output logic [DATA_W-1:0] rx_q,
  output logic              rx_avail
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q     <= '0;
      tx_empty <= 1'b1;
    end else if (tx_wr) begin
      tx_q     <= tx_in;
      tx_empty <= 1'b0;
    end else if (tx_accept) begin
      tx_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q     <= '0;
      rx_avail <= 1'b0;
    end else if (rx_push) begin
      rx_q     <= rx_in;
      rx_avail <= 1'b1;
    end else if (rx_rd) begin
      rx_avail <= 1'b0;
    end
  end

  AST_TX_WR_FILLS: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> (!tx_empty && tx_q == $past(tx_in))); // R5
  AST_TX_ACCEPT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (tx_accept && !tx_wr) |=> tx_empty); // R5
  AST_RX_PUSH_SETS: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> (rx_avail && rx_q == $past(rx_in))); // R6
  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && !rx_push) |=> !rx_avail); // R6
endmodule

// File: rtl/sccr_regfile.sv
module sccr_regfile
  import sccr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PTR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic            acc_data_port,
  input  logic [DW-1:0]   acc_wdata,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [DW-1:0]   tx_data,
  output logic            tx_loaded,
  input  logic            tx_accept,
  input  logic            rx_strobe,
  input  logic [DW-1:0]   rx_byte,
  output logic [2*DW-1:0] baud_tc
);
  logic          ctrl_wr, ctrl_rd, data_wr, data_rd;
  logic [PW-1:0] ptr;
  logic          reg_wr, reg_rd, stat_rd;
  logic [DW-1:0] bank_rdata, rx_q, status;
  logic          tx_empty, rx_avail;

  assign ctrl_wr = acc_valid &&  acc_write && (acc_data_port == PORT_CTRL);
  assign ctrl_rd = acc_valid && !acc_write && (acc_data_port == PORT_CTRL);
  assign data_wr = acc_valid &&  acc_write && (acc_data_port == PORT_DATA);
  assign data_rd = acc_valid && !acc_write && (acc_data_port == PORT_DATA);

  sccr_ptr #(.PTR_W(PW), .DATA_W(DW)) u_ptr (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd),
    .wdata(acc_wdata), .ptr(ptr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .stat_rd(stat_rd)
  );

  sccr_bank #(.PTR_W(PW), .DATA_W(DW), .BAUD_LO(BAUD_LO), .BAUD_HI(BAUD_HI)) u_bank (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .idx(ptr), .wdata(acc_wdata),
    .rdata(bank_rdata), .baud_tc(baud_tc)
  );

  sccr_latch #(.DATA_W(DW)) u_latch (
    .clk(clk), .rst(rst), .tx_wr(data_wr), .tx_in(acc_wdata),
    .tx_accept(tx_accept), .rx_rd(data_rd), .rx_push(rx_strobe),
    .rx_in(rx_byte), .tx_q(tx_data), .tx_empty(tx_empty), .rx_q(rx_q),
    .rx_avail(rx_avail)
  );

  always_comb begin
    status              = '0;
    status[STAT_RX_BIT] = rx_avail;
    status[STAT_TX_BIT] = tx_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= data_rd || reg_rd || stat_rd;
      if (data_rd)      rd_data <= rx_q;
      else if (stat_rd) rd_data <= status;
      else if (reg_rd)  rd_data <= bank_rdata;
    end
  end

  assign tx_loaded = !tx_empty;

  AST_RDV_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_valid && !acc_write)); // R8
  AST_NO_RDV_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write) |=> !rd_valid); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!rd_valid && tx_empty && !rx_avail && ptr == '0 && baud_tc == '0)); // R9
  AST_DATA_PORT_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_data_port == PORT_DATA) |=> $stable(ptr)); // R10
endmodule

// File: tb/sccr_regfile_bench.sv
module sccr_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_data_port = 1'b0;
  logic [7:0]  acc_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data, tx_data;
  logic        tx_loaded;
  logic        tx_accept = 1'b0, rx_strobe = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [15:0] baud_tc;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sccr_regfile u_sccr_regfile (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_data_port(acc_data_port), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .tx_data(tx_data), .tx_loaded(tx_loaded),
    .tx_accept(tx_accept), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
    .baud_tc(baud_tc)
  );

  // {write, data_port, wdata, expect_valid, expect_data}
  localparam int NV = 18;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h04},  // R3 R4 status after reset
    {1'b1, 1'b0, 8'hF5, 1'b0, 8'h00},  // R1 pointer 5, upper bits dropped
    {1'b1, 1'b0, 8'hA7, 1'b0, 8'h00},  // R2 R11 write reg 5
    {1'b1, 1'b0, 8'h05, 1'b0, 8'h00},  // R2 fresh pointer
    {1'b0, 1'b0, 8'h00, 1'b1, 8'hA7},  // R11 read reg 5
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h04},  // R2 pointer back at zero
    {1'b1, 1'b0, 8'h0C, 1'b0, 8'h00},  // R7
    {1'b1, 1'b0, 8'h34, 1'b0, 8'h00},  // R7 low byte
    {1'b1, 1'b0, 8'h0D, 1'b0, 8'h00},  // R7
    {1'b1, 1'b0, 8'h12, 1'b0, 8'h00},  // R7 high byte
    {1'b1, 1'b1, 8'h5A, 1'b0, 8'h00},  // R5 data write
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h00},  // R4 R5 TX-empty now clear
    {1'b1, 1'b0, 8'h0C, 1'b0, 8'h00},  // R10 pointer 12
    {1'b0, 1'b1, 8'h00, 1'b1, 8'h00},  // R10 data read, rx latch 0
    {1'b1, 1'b1, 8'h66, 1'b0, 8'h00},  // R10 data write
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h34},  // R10 pointer survived
    {1'b1, 1'b0, 8'h10, 1'b0, 8'h00},  // R1 masks to pointer 0
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h00}   // R1 still status phase
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs settled
  task automatic acc(input logic wr, input logic dp, input logic [7:0] wd);
    acc_valid = 1'b1; acc_write = wr; acc_data_port = dp; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic status_is(input string req, input logic [7:0] exp);
    acc(1'b0, 1'b0, 8'h00);
    chk(req, {rd_valid, rd_data}, {1'b1, exp});
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 reset rd_valid/tx_loaded/baud", {rd_valid, tx_loaded, baud_tc}, 18'h0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][18], VEC[i][17], VEC[i][16:9]);
      if (VEC[i][8]) chk($sformatf("R2/R3/R8/R11 vec%0d", i), {rd_valid, rd_data}, {1'b1, VEC[i][7:0]});
      else           chk($sformatf("R8 vec%0d no read", i), {31'b0, rd_valid}, 32'h0);
    end

    chk("R7 baud_tc", baud_tc, 16'h1234);
    chk("R5 tx_data", tx_data, 8'h66);
    chk("R5 tx_loaded", tx_loaded, 1'b1);

    tx_accept = 1'b1; @(negedge clk); tx_accept = 1'b0;
    status_is("R5 accept sets TX-empty", 8'h04);

    tx_accept = 1'b1; acc(1'b1, 1'b1, 8'h77); tx_accept = 1'b0;
    chk("R5 write wins over accept", {tx_loaded, tx_data}, {1'b1, 8'h77});
    status_is("R5 status after collision", 8'h00);

    rx_byte = 8'h3C; rx_strobe = 1'b1; @(negedge clk); rx_strobe = 1'b0;
    status_is("R6 RX-available set", 8'h01);
    acc(1'b0, 1'b1, 8'h00);
    chk("R6 data read", {rd_valid, rd_data}, {1'b1, 8'h3C});
    status_is("R6 RX-available cleared", 8'h00);

    rx_byte = 8'h11; rx_strobe = 1'b1; @(negedge clk);
    rx_byte = 8'h22; acc(1'b0, 1'b1, 8'h00); rx_strobe = 1'b0;
    chk("R6 collision returns old byte", {rd_valid, rd_data}, {1'b1, 8'h11});
    status_is("R6 push wins over read", 8'h01);
    acc(1'b0, 1'b1, 8'h00);
    chk("R6 new byte kept", rd_data, 8'h22);

    @(negedge clk);
    chk("R8 idle rd_valid low", {31'b0, rd_valid}, 32'h0);

    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    chk("R9 reset baud/tx_loaded", {tx_loaded, baud_tc}, 17'h0);
    status_is("R9 reset status", 8'h04);
    acc(1'b1, 1'b0, 8'h05);
    acc(1'b0, 1'b0, 8'h00);
    chk("R9 reg 5 cleared", {rd_valid, rd_data}, {1'b1, 8'h00});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule